// File: doc/BRIEF.md
# Clock-Controlled Filter Keystream Generator

This block is a bit-per-cycle keystream source built from two linear feedback shift registers. A 128-stage control register steps once on every active cycle. Two of its stages give a step count from 1 to 4, and that count sets how far a 127-stage data register moves in the same cycle. Twelve stages of the data register form the address of a 4096-entry, one-bit lookup table, and the table output is the keystream bit.

The user presents a key and an IV and pulses start. The block loads the key into the control register and the IV into the data register. It then runs two priming passes. In each pass it produces 255 bits, one per register stage, and writes them back as the new contents of both registers. After the second pass it enters the keystream phase. There it emits one valid bit per cycle until the next start or reset. The feedback tap masks and the filter table are parameters.

Top module: `ccnf_keystream`

## Requirements
- R1: After a synchronous reset, `busy_o` and `ks_valid_o` stay low until a start pulse is accepted.
- R2: A start pulse sampled while `busy_o` is low loads the key (all 128 bits) into the control register and the IV (all 127 bits) into the data register. `busy_o` is then high for exactly 514 cycles, which covers two passes of 255 steps each plus a 2-cycle drain after each pass.
- R3: `ks_valid_o` is low while `busy_o` is high and for the 2 cycles after `busy_o` falls. It is then high on every cycle.
- R4: On each step the step count is k = 2·c[0] + c[126] + 1, taken from the control register before the step. The control register moves one position and the data register moves k positions. A single move shifts the register toward its MSB and puts into bit 0 the parity of the state ANDed with that register's tap mask.
- R5: The keystream bit is the table entry at a 12-bit address whose bit i is data stage 11·i. The data state used is the one after that cycle's move. The bit appears at the output 2 cycles after the step.
- R6: Each priming pass writes its 255 bits back in production order. The first 128 bits go to control bits 127 down to 0. The next 127 bits go to data bits 126 down to 0.
- R7: A start pulse while `busy_o` is high has no effect on the timing or on the bits produced.
- R8: Any load value that is all zero (key, IV, or write-back) is replaced by the value with only bit 0 set, so neither register is all zero outside the idle state.
- R9: A start pulse during the keystream phase restarts loading and priming with the new key and IV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load key and IV and begin priming |
| key_i | input | 128 | Key, loaded into the control register |
| iv_i | input | 127 | IV, loaded into the data register |
| busy_o | output | 1 | High while priming runs |
| ks_bit_o | output | 1 | Keystream bit |
| ks_valid_o | output | 1 | Keystream bit is valid |

## Verification
On every cycle the checker confirms the following:
- the reset state;
- that valid never overlaps busy;
- the one-position move of the control register;
- the data register's shift for step counts 1 and 4;
- that neither register is ever zero once loaded;
- that a start during priming leaves priming running.

The bench's behavioural model supplies what a property cannot express. It covers the actual bit values through table lookup, the write-back order across both passes, the exact busy and valid windows, the replacement of an all-zero key and IV, and a restart from the keystream phase.

// File: rtl/ccnf_pkg.sv
package ccnf_pkg;
    localparam int CW         = 128;
    localparam int DW         = 127;
    localparam int NTAP       = 12;
    localparam int NSTEP      = 4;
    localparam int TAP_STRIDE = 11;
    localparam int TBL        = 1 << NTAP;
    localparam int INIT_BITS  = CW + DW;
    localparam int CNT_W      = $clog2(INIT_BITS + 1);
    localparam int KW         = $clog2(NSTEP);

    typedef logic [CW-1:0]   ctrl_t;
    typedef logic [DW-1:0]   data_t;
    typedef logic [NTAP-1:0] addr_t;

    typedef enum logic [1:0] {PH_IDLE, PH_INIT, PH_KEY} phase_e;

    typedef struct packed {
        addr_t [NSTEP-1:0] cand;
        logic  [KW-1:0]    ksel;
    } tap_pipe_t;

    localparam ctrl_t CTRL_TAPS_DEF = (ctrl_t'(1) << 127) | (ctrl_t'(1) << 126)
                                    | (ctrl_t'(1) << 125) | (ctrl_t'(1) << 120);
    localparam data_t DATA_TAPS_DEF = (data_t'(1) << 126) | (data_t'(1) << 125);

    function automatic ctrl_t ctrl_next(ctrl_t s, ctrl_t taps);
        return {s[CW-2:0], ^(s & taps)};
    endfunction

    function automatic data_t data_next(data_t s, data_t taps);
        return {s[DW-2:0], ^(s & taps)};
    endfunction

    function automatic addr_t tap_pick(data_t s);
        addr_t a;
        for (int i = 0; i < NTAP; i++) a[i] = s[i*TAP_STRIDE];
        return a;
    endfunction

    function automatic ctrl_t ctrl_nz(ctrl_t s);
        return (s == '0) ? ctrl_t'(1) : s;
    endfunction

    function automatic data_t data_nz(data_t s);
        return (s == '0) ? data_t'(1) : s;
    endfunction

    function automatic logic [TBL-1:0] filter_default();
        logic [TBL-1:0] t;
        for (int a = 0; a < TBL; a++) begin
            addr_t x = addr_t'(a);
            t[a] = x[0] ^ x[3] ^ x[7] ^ (x[1] & x[5]) ^ (x[2] & x[9] & x[11])
                 ^ (x[4] & x[6]) ^ (x[8] & x[10]);
        end
        return t;
    endfunction
endpackage

// File: rtl/ccnf_ctrl_lfsr.sv
module ccnf_ctrl_lfsr
    import ccnf_pkg::*;
#(
    parameter ctrl_t TAPS = CTRL_TAPS_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  ctrl_t         load_val,
    input  logic          step,
    output ctrl_t         state,
    output logic [KW-1:0] kcode
);
    // kcode is k-1: the index of the advanced data copy to take
    assign kcode = {state[0], state[CW-2]};

    always_ff @(posedge clk) begin
        if (rst)       state <= '0;
        else if (load) state <= load_val;
        else if (step) state <= ctrl_next(state, TAPS);
    end
endmodule

// File: rtl/ccnf_data_lfsr.sv
module ccnf_data_lfsr
    import ccnf_pkg::*;
#(
    parameter data_t TAPS = DATA_TAPS_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  data_t         load_val,
    input  logic          step,
    input  logic [KW-1:0] kcode,
    output data_t         state,
    output tap_pipe_t     pipe
);
    data_t adv [NSTEP];

    assign adv[0] = data_next(state, TAPS);
    for (genvar j = 1; j < NSTEP; j++) begin : g_adv
        assign adv[j] = data_next(adv[j-1], TAPS);
    end

    always_ff @(posedge clk) begin
        if (rst)       state <= '0;
        else if (load) state <= load_val;
        else if (step) state <= adv[kcode];
    end

    // equal-latency registers on the tap outputs of every advanced copy
    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            for (int j = 0; j < NSTEP; j++) pipe.cand[j] <= tap_pick(adv[j]);
            pipe.ksel <= kcode;
        end
    end
endmodule

// File: rtl/ccnf_filter.sv
module ccnf_filter
    import ccnf_pkg::*;
#(
    parameter logic [TBL-1:0] TABLE = filter_default()
) (
    input  logic      clk,
    input  logic      rst,
    input  tap_pipe_t pipe,
    output logic      z
);
    addr_t addr;
    assign addr = pipe.cand[pipe.ksel];

    always_ff @(posedge clk) begin
        if (rst) z <= 1'b0;
        else     z <= TABLE[addr];
    end
endmodule

// File: rtl/ccnf_keystream.sv
module ccnf_keystream
    import ccnf_pkg::*;
#(
    parameter ctrl_t          CTRL_TAPS    = CTRL_TAPS_DEF,
    parameter data_t          DATA_TAPS    = DATA_TAPS_DEF,
    parameter logic [TBL-1:0] FILTER_TABLE = filter_default()
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [CW-1:0] key_i,
    input  logic [DW-1:0] iv_i,
    output logic          busy_o,
    output logic          ks_bit_o,
    output logic          ks_valid_o
);
    phase_e                phase;
    logic                  pass;
    logic [CNT_W-1:0]      scnt;
    logic [CNT_W-1:0]      bcnt;
    logic [INIT_BITS-1:0]  wb;
    logic [INIT_BITS-1:0]  wb_next;
    logic                  v1, v2;
    logic                  accept, step, capture, reload, load;
    logic [KW-1:0]         kcode;
    ctrl_t                 c_state, c_load;
    data_t                 d_state, d_load;
    tap_pipe_t             pipe;
    logic                  z;

    assign accept  = start_i && (phase != PH_INIT);
    assign step    = (phase == PH_KEY) ||
                     ((phase == PH_INIT) && (scnt < CNT_W'(INIT_BITS)));
    assign capture = (phase == PH_INIT) && v2;
    assign reload  = capture && (bcnt == CNT_W'(INIT_BITS - 1));
    assign load    = accept || reload;
    assign wb_next = {wb[INIT_BITS-2:0], z};
    assign c_load  = accept ? ctrl_nz(key_i) : ctrl_nz(wb_next[INIT_BITS-1 -: CW]);
    assign d_load  = accept ? data_nz(iv_i)  : data_nz(wb_next[DW-1:0]);

    ccnf_ctrl_lfsr #(.TAPS(CTRL_TAPS)) u_ctrl (
        .clk(clk), .rst(rst), .load(load), .load_val(c_load), .step(step),
        .state(c_state), .kcode(kcode)
    );

    ccnf_data_lfsr #(.TAPS(DATA_TAPS)) u_data (
        .clk(clk), .rst(rst), .load(load), .load_val(d_load), .step(step),
        .kcode(kcode), .state(d_state), .pipe(pipe)
    );

    ccnf_filter #(.TABLE(FILTER_TABLE)) u_filt (
        .clk(clk), .rst(rst), .pipe(pipe), .z(z)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            pass  <= 1'b0;
            scnt  <= '0;
            bcnt  <= '0;
            wb    <= '0;
            v1    <= 1'b0;
            v2    <= 1'b0;
        end else begin
            v1 <= step && !load;
            v2 <= accept ? 1'b0 : v1;
            if (accept) begin
                phase <= PH_INIT;
                pass  <= 1'b0;
                scnt  <= '0;
                bcnt  <= '0;
            end else if (phase == PH_INIT) begin
                if (step) scnt <= scnt + 1'b1;
                if (capture) begin
                    wb   <= wb_next;
                    bcnt <= bcnt + 1'b1;
                end
                if (reload) begin
                    scnt <= '0;
                    bcnt <= '0;
                    if (pass) phase <= PH_KEY;
                    else      pass  <= 1'b1;
                end
            end
        end
    end

    assign busy_o     = (phase == PH_INIT);
    assign ks_valid_o = v2 && (phase == PH_KEY);
    assign ks_bit_o   = z;
endmodule

// File: rtl/ccnf_keystream_chk.sv
module ccnf_keystream_chk
    import ccnf_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             busy_o,
    input logic             ks_valid_o,
    input phase_e           phase,
    input ctrl_t            c_state,
    input data_t            d_state,
    input logic             step,
    input logic             load,
    input logic             reload,
    input logic [KW-1:0]    kcode,
    input logic [CNT_W-1:0] scnt
);
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy_o && !ks_valid_o));

    p_valid_not_busy_r3: assert property (@(posedge clk) disable iff (rst)
        ks_valid_o |-> !busy_o);

    p_ctrl_shift_r4: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (c_state[CW-1:1] == $past(c_state[CW-2:0])));

    p_data_k1_r4: assert property (@(posedge clk) disable iff (rst)
        (step && !load && kcode == 2'd0) |=> (d_state[DW-1:1] == $past(d_state[DW-2:0])));

    p_data_k4_r4: assert property (@(posedge clk) disable iff (rst)
        (step && !load && kcode == 2'd3) |=> (d_state[DW-1:4] == $past(d_state[DW-5:0])));

    p_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |-> ((c_state != '0) && (d_state != '0)));

    p_start_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && !reload) |=> (busy_o && scnt >= $past(scnt)));
endmodule

bind ccnf_keystream ccnf_keystream_chk u_chk (
    .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o),
    .ks_valid_o(ks_valid_o), .phase(phase), .c_state(c_state),
    .d_state(d_state), .step(step), .load(load), .reload(reload),
    .kcode(kcode), .scnt(scnt)
);

// File: tb/ccnf_keystream_tb.sv
module ccnf_keystream_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [127:0] TB_CTAPS = (128'd1 << 127) | (128'd1 << 126)
                                      | (128'd1 << 125) | (128'd1 << 120);
    localparam logic [126:0] TB_DTAPS = (127'd1 << 126) | (127'd1 << 125);

    function automatic logic [4095:0] tb_table();
        logic [4095:0] t;
        for (int a = 0; a < 4096; a++) begin
            logic [11:0] x = a[11:0];
            t[a] = x[11] ^ x[4] ^ x[1] ^ (x[0] & x[6]) ^ (x[2] & x[3] & x[9])
                 ^ (x[5] & x[8]) ^ (x[7] & x[10] & x[11]);
        end
        return t;
    endfunction
    localparam logic [4095:0] TB_TABLE = tb_table();

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [127:0] key_i = '0;
    logic [126:0] iv_i = '0;
    logic busy_o, ks_bit_o, ks_valid_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [127:0] mc;
    logic [126:0] md;
    bit exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ccnf_keystream #(.CTRL_TAPS(TB_CTAPS), .DATA_TAPS(TB_DTAPS), .FILTER_TABLE(TB_TABLE)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .key_i(key_i), .iv_i(iv_i),
        .busy_o(busy_o), .ks_bit_o(ks_bit_o), .ks_valid_o(ks_valid_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference model: behavioural, bit by bit
    function automatic logic [127:0] m_cmove(logic [127:0] s);
        bit fb = 0;
        for (int i = 0; i < 128; i++) if (TB_CTAPS[i]) fb ^= s[i];
        return {s[126:0], fb};
    endfunction

    function automatic logic [126:0] m_dmove(logic [126:0] s);
        bit fb = 0;
        for (int i = 0; i < 127; i++) if (TB_DTAPS[i]) fb ^= s[i];
        return {s[125:0], fb};
    endfunction

    task automatic m_gen(output bit b);
        int k;
        int addr;
        k = 2 * int'(mc[0]) + int'(mc[126]) + 1;   // R4 step count
        mc = m_cmove(mc);
        for (int s = 0; s < k; s++) md = m_dmove(md);
        addr = 0;
        for (int i = 0; i < 12; i++) if (md[11*i]) addr += (1 << i);  // R5 address
        b = TB_TABLE[addr];
    endtask

    task automatic m_prepare(input logic [127:0] key, input logic [126:0] iv, input int nbits);
        bit bits [255];
        bit b;
        mc = (key == '0) ? 128'd1 : key;   // R8
        md = (iv == '0) ? 127'd1 : iv;
        for (int p = 0; p < 2; p++) begin   // R6 two write-back passes
            for (int j = 0; j < 255; j++) begin
                m_gen(b);
                bits[j] = b;
            end
            for (int i = 0; i < 128; i++) mc[127-i] = bits[i];
            for (int i = 0; i < 127; i++) md[126-i] = bits[128+i];
            if (mc == '0) mc = 128'd1;
            if (md == '0) md = 127'd1;
        end
        exp_q.delete();
        for (int j = 0; j < nbits; j++) begin
            m_gen(b);
            exp_q.push_back(b);
        end
    endtask

    task automatic run_session(input logic [127:0] key, input logic [126:0] iv,
                               input int nbits, input bit poke, input string tag);
        int n;
        int got;
        m_prepare(key, iv, nbits);
        @(negedge clk);
        start_i = 1'b1;
        key_i = key;
        iv_i = iv;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        got = 0;
        while (got < nbits) begin
            chk(busy_o == (n < 514), {tag, " R2 busy window"}, int'(busy_o), int'(n < 514));
            chk(ks_valid_o == (n >= 516), {tag, " R3 valid window"}, int'(ks_valid_o), int'(n >= 516));
            if (ks_valid_o) begin
                bit e = exp_q.pop_front();
                chk(ks_bit_o == e, {tag, " R4 R5 R6 keystream bit"}, int'(ks_bit_o), int'(e));
                got++;
            end
            if (poke && n == 100) begin   // R7 start while busy
                start_i = 1'b1;
                key_i = ~key;
                iv_i = ~iv;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            n++;
            if (n > 700) break;
        end
        chk(got == nbits, {tag, " bit count"}, got, nbits);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            chk(!busy_o && !ks_valid_o, "R1 reset idle", int'(busy_o | ks_valid_o), 0);
            @(negedge clk);
        end
        run_session({4{32'h1234_5678}}, {127{1'b1}} ^ 127'h5a5a_0f0f, 64, 0, "S1");
        run_session({4{32'h9abc_def0}}, 127'h3c3c_a5a5_0001, 48, 0, "R9 restart");
        run_session({2{64'hdead_beef_0bad_f00d}}, 127'h77, 48, 1, "R7 poke");
        run_session('0, '0, 48, 0, "R8 zero");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule